// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold Events

This block sits between a 16-bit host register port and an I2C shift engine. It holds two byte queues: a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host empties. A configuration register sets a receive threshold, a transmit threshold, two DMA enables and two one-shot flush controls.

A count register gives the number of bytes in the current transfer. The block keeps, for each direction, how many of those bytes the host still has to move. From the thresholds, the queue levels and these counts it raises ready events and draining events for an interrupt controller, and DMA requests.

A ready event marks a full threshold-sized chunk. A draining event marks the final chunk of a counted transfer, which is smaller than the threshold. A status register reports the queue size code and, per direction, how many bytes the host may move right now.

Top module: `i2c_byte_fifos`

## Requirements
- R1: After reset all events, DMA requests and pulse flags are low, the transmit queue reports no byte available to the engine, and the configuration and status registers read 0x0000 (with size code 0).
- R2: Each queue is first-in first-out. Bytes written to the data register (address 0) leave on `eng_tx_byte` in order. Bytes pushed by the engine are returned in order by data register reads, in `reg_rdata[7:0]`, with the upper byte zero.
- R3: A data write to a full transmit queue is dropped and pulses `tx_overflow` for one cycle. An engine push into a full receive queue is dropped and pulses `rx_overrun` for one cycle. Queued bytes are never overwritten.
- R4: A data read from an empty receive queue returns 0x0000 and does not reduce the receive bytes-left count.
- R5: Configuration register (address 1) layout: bit 15 receive DMA enable, bit 14 receive flush, bits 13:8 receive threshold minus one, bit 7 transmit DMA enable, bit 6 transmit flush, bits 5:0 transmit threshold minus one. Flush bits read back as zero; all other bits read back as written.
- R6: Writing a flush bit empties that queue at the clock edge after the write.
- R7: The receive threshold is field+1, capped at the queue depth. `ev_rx_ready` is high while the receive level is at least that threshold.
- R8: The transmit threshold is field+1, capped at the depth. `ev_tx_ready` is high while the free space and the transmit bytes-left count are both at least that threshold.
- R9: A draining event is high when its bytes-left count is nonzero and below the threshold, the level (receive) or free space (transmit) covers that count, and the ready event of the same direction is low.
- R10: Status register (address 3): bits 15:14 size code (depth = 8 shifted left by it), bits 13:7 the smaller of receive bytes-left and receive level, bits 6:0 the smaller of transmit bytes-left and free space.
- R11: Writing the count register (address 2) loads both bytes-left counts, and the register reads back as written. Each accepted data write lowers the transmit count by one and each accepted data read lowers the receive count by one, stopping at zero.
- R12: `dma_rx_req` is high when receive DMA is enabled and a receive ready or draining event holds; `dma_tx_req` is high in the same way for transmit.
- R13: Events, DMA requests and status fields are registered: they reflect queue and count state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 config, 2 count, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Byte taken by the last pop (zero if the queue was empty) |
| eng_tx_avail | output | 1 | Transmit queue is not empty |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_space | output | 1 | Receive queue is not full |
| ev_rx_ready | output | 1 | Receive threshold chunk available |
| ev_rx_drain | output | 1 | Final receive chunk available |
| ev_tx_ready | output | 1 | Transmit threshold chunk of space available |
| ev_tx_drain | output | 1 | Space for the final transmit chunk |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| tx_overflow | output | 1 | One-cycle pulse: data write dropped |
| rx_overrun | output | 1 | One-cycle pulse: engine byte dropped |

## Verification
The bench sweeps threshold, transfer count and fill level through a table. The table includes a last chunk that is exactly present, one that is one byte short, a zero count, and a threshold field past the depth. A design that compares against the raw field, or fires draining without a counted transfer, gives the wrong events there. Directed cases read an empty receive queue and then confirm the bytes-left figure has not moved. They also overfill both queues and check that the first byte is kept and the extra one vanishes. Further cases check that the events lag a push by exactly one clock and that flush bits read back zero while the flush still empties the queue.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_CFG    = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       rx_dma;
    logic [5:0] rx_thf;
    logic       tx_dma;
    logic [5:0] tx_thf;
  } cfg_t;

  // flush positions (14 and 6) always read back as zero
  function automatic logic [15:0] cfg_pack(cfg_t c);
    return {c.rx_dma, 1'b0, c.rx_thf, c.tx_dma, 1'b0, c.tx_thf};
  endfunction

endpackage

// File: rtl/i2cf_byte_fifo.sv
module i2cf_byte_fifo #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic          push_ok;
  logic          pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (pop) dout <= pop_ok ? mem[rptr] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/i2cf_chunk_events.sv
module i2cf_chunk_events #(
  parameter int DEPTH = 8,
  parameter bit IS_TX = 1'b0,
  parameter int CW    = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [5:0]    thr_field,
  input  logic          dma_en,
  input  logic [LW-1:0] level,
  input  logic [CW-1:0] left,
  output logic          ready,
  output logic          drain,
  output logic          dma_req,
  output logic [6:0]    remain
);

  logic [6:0]    thr_raw;
  logic [6:0]    thr;
  logic [6:0]    avail;
  logic [CW-1:0] thr_w;
  logic [CW-1:0] avail_w;
  logic          ready_n;
  logic          drain_n;
  logic [6:0]    remain_n;

  always_comb begin
    thr_raw = {1'b0, thr_field} + 7'd1;
    thr     = (thr_raw > 7'(DEPTH)) ? 7'(DEPTH) : thr_raw;
    // receive side counts stored bytes, transmit side counts free slots
    avail   = IS_TX ? (7'(DEPTH) - 7'(level)) : 7'(level);
    thr_w   = CW'(thr);
    avail_w = CW'(avail);
    ready_n = (avail_w >= thr_w) && (!IS_TX || (left >= thr_w));
    drain_n = !ready_n && (left != '0) && (left < thr_w) && (avail_w >= left);
    remain_n = (left < avail_w) ? left[6:0] : avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      drain   <= 1'b0;
      dma_req <= 1'b0;
      remain  <= '0;
    end else begin
      ready   <= ready_n;
      drain   <= drain_n;
      dma_req <= dma_en && (ready_n || drain_n);
      remain  <= remain_n;
    end
  end

endmodule

// File: rtl/i2c_byte_fifos.sv
module i2c_byte_fifos
  import i2cf_pkg::*;
#(
  parameter int SIZE_CODE = 0,
  localparam int DEPTH = 8 << SIZE_CODE,
  localparam int LW    = $clog2(DEPTH) + 1,
  localparam int CW    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_byte,
  output logic        eng_tx_avail,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_byte,
  output logic        eng_rx_space,
  output logic        ev_rx_ready,
  output logic        ev_rx_drain,
  output logic        ev_tx_ready,
  output logic        ev_tx_drain,
  output logic        dma_rx_req,
  output logic        dma_tx_req,
  output logic        tx_overflow,
  output logic        rx_overrun
);

  cfg_t          cfg_q;
  logic          rx_flush_q, tx_flush_q;
  logic [CW-1:0] cnt_q, tx_left, rx_left;
  logic          sel_data_q;
  logic [15:0]   hold_q;
  logic          wr_data, rd_data, wr_cfg, wr_cnt;
  logic          tx_acc, rx_acc;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]    rx_dout;
  logic [6:0]    rx_rem, tx_rem;
  logic          rx_dma_en, tx_dma_en;
  logic [15:0]   status;

  assign wr_data   = reg_wr && (reg_addr == REG_DATA);
  assign wr_cfg    = reg_wr && (reg_addr == REG_CFG);
  assign wr_cnt    = reg_wr && (reg_addr == REG_COUNT);
  assign rd_data   = reg_rd && (reg_addr == REG_DATA);
  assign tx_acc    = wr_data && !tx_full && !tx_flush_q;
  assign rx_acc    = rd_data && !rx_empty && !rx_flush_q;
  assign rx_dma_en = cfg_q.rx_dma;
  assign tx_dma_en = cfg_q.tx_dma;
  assign status    = {2'(SIZE_CODE), rx_rem, tx_rem};

  assign eng_tx_avail = !tx_empty;
  assign eng_rx_space = !rx_full;

  // configuration and one-shot flush strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
    end else begin
      rx_flush_q <= wr_cfg && reg_wdata[14];
      tx_flush_q <= wr_cfg && reg_wdata[6];
      if (wr_cfg) begin
        cfg_q.rx_dma <= reg_wdata[15];
        cfg_q.rx_thf <= reg_wdata[13:8];
        cfg_q.tx_dma <= reg_wdata[7];
        cfg_q.tx_thf <= reg_wdata[5:0];
      end
    end
  end

  // transfer byte counters
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      tx_left <= '0;
      rx_left <= '0;
    end else if (wr_cnt) begin
      cnt_q   <= reg_wdata;
      tx_left <= reg_wdata;
      rx_left <= reg_wdata;
    end else begin
      if (tx_acc && tx_left != '0) tx_left <= tx_left - 1'b1;
      if (rx_acc && rx_left != '0) rx_left <= rx_left - 1'b1;
    end
  end

  // drop flags
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_overflow <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      tx_overflow <= wr_data && tx_full;
      rx_overrun  <= eng_rx_push && rx_full;
    end
  end

  // read path: data byte comes from the queue read port, others from hold_q
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_data_q <= 1'b0;
      hold_q     <= '0;
    end else if (reg_rd) begin
      sel_data_q <= (reg_addr == REG_DATA);
      case (reg_addr)
        REG_CFG:    hold_q <= cfg_pack(cfg_q);
        REG_COUNT:  hold_q <= cnt_q;
        REG_STATUS: hold_q <= status;
        default:    hold_q <= hold_q;
      endcase
    end
  end

  assign reg_rdata = sel_data_q ? {8'h00, rx_dout} : hold_q;

  i2cf_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (tx_flush_q),
    .push  (wr_data),
    .din   (reg_wdata[7:0]),
    .pop   (eng_tx_pop),
    .dout  (eng_tx_byte),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  i2cf_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (rx_flush_q),
    .push  (eng_rx_push),
    .din   (eng_rx_byte),
    .pop   (rd_data),
    .dout  (rx_dout),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  i2cf_chunk_events #(.DEPTH(DEPTH), .IS_TX(1'b0), .CW(CW)) u_rx_ev (
    .clk       (clk),
    .rst       (rst),
    .thr_field (cfg_q.rx_thf),
    .dma_en    (rx_dma_en),
    .level     (rx_level),
    .left      (rx_left),
    .ready     (ev_rx_ready),
    .drain     (ev_rx_drain),
    .dma_req   (dma_rx_req),
    .remain    (rx_rem)
  );

  i2cf_chunk_events #(.DEPTH(DEPTH), .IS_TX(1'b1), .CW(CW)) u_tx_ev (
    .clk       (clk),
    .rst       (rst),
    .thr_field (cfg_q.tx_thf),
    .dma_en    (tx_dma_en),
    .level     (tx_level),
    .left      (tx_left),
    .ready     (ev_tx_ready),
    .drain     (ev_tx_drain),
    .dma_req   (dma_tx_req),
    .remain    (tx_rem)
  );

endmodule

// File: rtl/i2c_byte_fifos_chk.sv
module i2c_byte_fifos_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_flush_q,
  input logic          tx_flush_q,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          tx_overflow,
  input logic          rx_overrun,
  input logic          ev_rx_ready,
  input logic          ev_rx_drain,
  input logic          ev_tx_ready,
  input logic          ev_tx_drain,
  input logic          dma_rx_req,
  input logic          dma_tx_req,
  input logic          rx_dma_en,
  input logic          tx_dma_en
);

  a_r6_rx_flush: assert property (@(posedge clk) disable iff (rst)
    rx_flush_q |=> (rx_level == '0));

  a_r6_tx_flush: assert property (@(posedge clk) disable iff (rst)
    tx_flush_q |=> (tx_level == '0));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  a_r3_tx_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    tx_overflow |-> ($past(tx_level) == LW'(DEPTH)));

  a_r3_rx_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> ($past(rx_level) == LW'(DEPTH)));

  a_r9_rx_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ev_rx_ready && ev_rx_drain));

  a_r9_tx_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ev_tx_ready && ev_tx_drain));

  a_r12_rx_dma_gated: assert property (@(posedge clk) disable iff (rst)
    dma_rx_req |-> $past(rx_dma_en));

  a_r12_tx_dma_gated: assert property (@(posedge clk) disable iff (rst)
    dma_tx_req |-> $past(tx_dma_en));

endmodule

bind i2c_byte_fifos i2c_byte_fifos_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_flush_q  (rx_flush_q),
  .tx_flush_q  (tx_flush_q),
  .rx_level    (rx_level),
  .tx_level    (tx_level),
  .tx_overflow (tx_overflow),
  .rx_overrun  (rx_overrun),
  .ev_rx_ready (ev_rx_ready),
  .ev_rx_drain (ev_rx_drain),
  .ev_tx_ready (ev_tx_ready),
  .ev_tx_drain (ev_tx_drain),
  .dma_rx_req  (dma_rx_req),
  .dma_tx_req  (dma_tx_req),
  .rx_dma_en   (rx_dma_en),
  .tx_dma_en   (tx_dma_en)
);

// File: tb/i2c_byte_fifos_bench.sv
module i2c_byte_fifos_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_DATA = 2'd0, A_CFG = 2'd1, A_CNT = 2'd2, A_STAT = 2'd3;

  // {thr field, count, engine pushes, {ready, drain, rx remain[5:0]}}
  localparam logic [31:0] VEC [8] = '{
    32'h030A0484, 32'h030A0303, 32'h03020242, 32'h03030202,
    32'h00050181, 32'h14140888, 32'h14140707, 32'h07000500
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_byte;
  logic        eng_tx_avail;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_rx_space;
  logic        ev_rx_ready, ev_rx_drain, ev_tx_ready, ev_tx_drain;
  logic        dma_rx_req, dma_tx_req, tx_overflow, rx_overrun;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_fifos u_i2c_byte_fifos (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_byte(eng_tx_byte), .eng_tx_avail(eng_tx_avail), .eng_rx_push(eng_rx_push),
    .eng_rx_byte(eng_rx_byte), .eng_rx_space(eng_rx_space), .ev_rx_ready(ev_rx_ready),
    .ev_rx_drain(ev_rx_drain), .ev_tx_ready(ev_tx_ready), .ev_tx_drain(ev_tx_drain),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req), .tx_overflow(tx_overflow),
    .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_byte = b;
    @(posedge clk); @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_pop(output logic [7:0] b);
    eng_tx_pop = 1'b1;
    @(posedge clk); @(negedge clk);
    eng_tx_pop = 1'b0;
    b = eng_tx_byte;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    chk("R1 events", {8'h00, ev_rx_ready, ev_rx_drain, ev_tx_ready, ev_tx_drain,
        dma_rx_req, dma_tx_req, tx_overflow, rx_overrun}, 16'h0000);
    chk("R1 tx avail", {15'h0, eng_tx_avail}, 16'h0000);
    reg_read(A_STAT, v); chk("R1 status", v, 16'h0000);
    reg_read(A_CFG, v);  chk("R1 config", v, 16'h0000);

    // R5 config readback, flush bits zero
    reg_write(A_CFG, 16'hC5C3);
    reg_read(A_CFG, v); chk("R5 config readback", v, 16'h8583);

    // table: R7 / R9 / R10 on the receive side
    for (int i = 0; i < 8; i++) begin
      logic [31:0] row;
      row = VEC[i];
      reg_write(A_CFG, {2'b01, row[29:24], 8'h40});
      reg_write(A_CNT, {8'h00, row[23:16]});
      for (int j = 0; j < int'(row[15:8]); j++) rx_push(8'(i * 16 + j));
      idle(2);
      chk($sformatf("R7 ready row %0d", i), {15'h0, ev_rx_ready}, {15'h0, row[7]});
      chk($sformatf("R9 drain row %0d", i), {15'h0, ev_rx_drain}, {15'h0, row[6]});
      reg_read(A_STAT, v);
      chk($sformatf("R10 rx remain row %0d", i), {9'h0, v[13:7]}, {10'h0, row[5:0]});
    end

    // R13 one-cycle lag, then R7
    reg_write(A_CFG, 16'h4100);
    reg_write(A_CNT, 16'h0010);
    rx_push(8'h5A);
    rx_push(8'hA5);
    chk("R13 ready lag", {15'h0, ev_rx_ready}, 16'h0000);
    idle(1);
    chk("R7 ready at threshold", {15'h0, ev_rx_ready}, 16'h0001);

    // R12 DMA gating
    reg_write(A_CFG, 16'h8100);
    idle(2);
    chk("R12 rx dma on", {15'h0, dma_rx_req}, 16'h0001);
    reg_write(A_CFG, 16'h0100);
    idle(2);
    chk("R12 rx dma off", {14'h0, dma_rx_req, ev_rx_ready}, 16'h0001);

    // R2 receive order, R11 count readback
    reg_read(A_DATA, v); chk("R2 rx first", v, 16'h005A);
    reg_read(A_DATA, v); chk("R2 rx second", v, 16'h00A5);
    reg_read(A_CNT, v);  chk("R11 count readback", v, 16'h0010);

    // R4 empty read
    reg_write(A_CFG, 16'h4000);
    reg_write(A_CNT, 16'h0003);
    reg_read(A_DATA, v); chk("R4 empty read", v, 16'h0000);
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
    idle(2);
    reg_read(A_STAT, v); chk("R4 left unchanged", {9'h0, v[13:7]}, 16'h0003);
    reg_read(A_DATA, v); chk("R2 rx byte", v, 16'h0011);
    idle(2);
    reg_read(A_STAT, v); chk("R11 rx left decrement", {9'h0, v[13:7]}, 16'h0002);

    // R3 receive overrun
    reg_write(A_CFG, 16'h4000);
    idle(1);
    for (int j = 0; j < 8; j++) rx_push(8'h80 + 8'(j));
    chk("R3 rx space", {15'h0, eng_rx_space}, 16'h0000);
    rx_push(8'hEE);
    chk("R3 rx overrun pulse", {15'h0, rx_overrun}, 16'h0001);
    idle(1);
    chk("R3 rx overrun ends", {15'h0, rx_overrun}, 16'h0000);
    for (int j = 0; j < 8; j++) reg_read(A_DATA, v);
    chk("R3 rx last kept", v, 16'h0087);

    // R8 / R9 / R10 / R2 transmit
    reg_write(A_CFG, 16'h0041);
    reg_write(A_CNT, 16'h0003);
    idle(2);
    chk("R8 tx ready", {15'h0, ev_tx_ready}, 16'h0001);
    reg_read(A_STAT, v); chk("R10 tx remain", {9'h0, v[6:0]}, 16'h0003);
    reg_write(A_DATA, 16'h00A1);
    idle(2);
    chk("R8 tx ready left2", {14'h0, ev_tx_ready, ev_tx_drain}, 16'h0002);
    reg_write(A_DATA, 16'h00A2);
    idle(2);
    chk("R9 tx drain", {14'h0, ev_tx_ready, ev_tx_drain}, 16'h0001);
    reg_write(A_DATA, 16'h00A3);
    idle(2);
    chk("R9 tx done", {14'h0, ev_tx_ready, ev_tx_drain}, 16'h0000);
    tx_pop(b); chk("R2 tx first", {8'h0, b}, 16'h00A1);
    tx_pop(b); chk("R2 tx second", {8'h0, b}, 16'h00A2);
    tx_pop(b); chk("R2 tx third", {8'h0, b}, 16'h00A3);
    chk("R2 tx empty", {15'h0, eng_tx_avail}, 16'h0000);

    // R3 transmit overflow
    reg_write(A_CFG, 16'h0040);
    reg_write(A_CNT, 16'h0014);
    for (int j = 0; j < 8; j++) reg_write(A_DATA, 16'h00B0 + 16'(j));
    reg_write(A_DATA, 16'h00C9);
    chk("R3 tx overflow pulse", {15'h0, tx_overflow}, 16'h0001);
    idle(1);
    chk("R3 tx overflow ends", {15'h0, tx_overflow}, 16'h0000);
    tx_pop(b); chk("R3 tx first kept", {8'h0, b}, 16'h00B0);
    for (int j = 0; j < 7; j++) tx_pop(b);
    chk("R3 tx last kept", {8'h0, b}, 16'h00B7);
    chk("R3 tx drained", {15'h0, eng_tx_avail}, 16'h0000);

    // R6 flush
    reg_write(A_DATA, 16'h0001);
    reg_write(A_DATA, 16'h0002);
    idle(1);
    chk("R6 tx filled", {15'h0, eng_tx_avail}, 16'h0001);
    reg_write(A_CFG, 16'h0040);
    idle(1);
    chk("R6 tx flushed", {15'h0, eng_tx_avail}, 16'h0000);
    reg_read(A_CFG, v); chk("R5 flush reads zero", v, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule